// File: doc/BRIEF.md
# Hot-Swap Channel Fault Sequencer

This block is the digital sequencer for one channel of a hot-swap power switch. It watches an active-low channel enable, a per-channel supply-good flag, a global-ready flag and the output of a current-limit comparator. From these it decides when the external switch's gate may be driven. All delays are counted in ticks of a one-microsecond timebase strobe. Every delay is a parameter, so a simulation can use short windows.

On turn-on the enable is synchronised and then debounced. The gate is then requested, and a start-up blanking window runs. The channel fails if the current limit is still active when that window ends. After start-up, one qualified overcurrent never trips the channel by itself. It starts a blanking window, and an arm window follows. Only a second qualified overcurrent inside the arm window latches the channel off.

A latched fault is cleared in three ways:
- the enable is held inactive for a set time;
- the supply-good or global-ready flag is lost;
- in the auto-retry variant only, a cool-down interval expires.

A separate fast-pulldown strobe marks each new current-limit event at once, with no filtering.

Top module: `hsw_fault_seq`

## Requirements
- R1: The gate request (gate_on = 1) rises only after DEB_TICKS ticks during which the synchronised enable is low (en_n = 0) and supply_ok = 1 without break. If either condition drops, the debounce count restarts from zero.
- R2: The start-up blanking window lasts SU_TICKS ticks after gate_on rises. If ilim_act = 1 on the tick that ends it, the channel latches a fault. Otherwise the channel stays on with fault = 0.
- R3: After start-up, a current-limit pulse that covers fewer than FILT_TICKS ticks has no effect on the channel. This holds even inside the arm window.
- R4: A current limit that covers FILT_TICKS ticks qualifies and starts a blanking window of OCB_TICKS ticks. An arm window of ARM_TICKS ticks follows. Take k as the tick count from the first qualification to the second. A second qualification latches a fault exactly when OCB_TICKS <= k <= OCB_TICKS + ARM_TICKS - 1.
- R5: A second qualification outside the arm window does not trip the channel. If it comes on the tick that closes the arm window, or later, it only starts a new blanking window.
- R6: A latched fault drives gate_on = 0 and fault = 1. With AUTO_RETRY = 0, the fault persists for any number of ticks while the enable stays low and both ready flags stay high.
- R7: A fault clears (fault = 0) after the synchronised enable has been high (en_n = 1) for CLR_TICKS ticks in a row. A shorter high period restarts the count. A new turn-on after the clear again takes the full debounce.
- R8: With AUTO_RETRY = 1, a fault clears by itself after COOL_TICKS ticks. If the enable is still low, the debounce then restarts.
- R9: Dropping supply_ok or global_ok to 0 forces gate_on = 0 and fault = 0 on the next clock edge, from any state.
- R10: fast_pd is 1 in the very cycle where ilim_act rises from 0 to 1, and 0 at all other times.
- R11: After reset, gate_on = 0, fault = 0 and fast_pd = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Asynchronous active-low channel enable |
| supply_ok | input | 1 | Channel supply above its undervoltage level |
| global_ok | input | 1 | Main supply out of lockout and ready |
| ilim_act | input | 1 | Current-limit amplifier is regulating (overcurrent) |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| gate_on | output | 1 | Request to drive the external switch gate |
| fast_pd | output | 1 | Request for fast gate pulldown on a new current-limit event |
| fault | output | 1 | Overcurrent fault latched |

## Verification
Two events can fall in the same cycle. One is the tick that closes the arm window. The other is the tick that completes a second overcurrent qualification. The bench provokes this by sweeping the gap between the first and the second qualification one tick at a time across the whole blanking-plus-arm span. For each gap it predicts the fault arithmetically from R4: the last in-window gap must trip, and the gap exactly at the window's close must not. A second sweep varies the pulse length inside the arm window, so that a pulse one tick short of qualification is told apart from one that qualifies.

// File: rtl/hsw_pkg.sv
// Package: shared types for the hot-swap channel sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package hsw_pkg;

    // Channel sequencer states; ST_OFF is the reset state.
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_DEBOUNCE = 3'd1,
        ST_STARTUP  = 3'd2,
        ST_RUN      = 3'd3,
        ST_OC_BLANK = 3'd4,
        ST_ARMED    = 3'd5,
        ST_FAULT    = 3'd6
    } hsw_state_e;

endpackage

// File: rtl/hsw_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes: STAGES >= 2; RST_VAL is the inactive level of the input.
module hsw_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/hsw_tick_timer.sv
// Module: saturating tick counter with synchronous clear.
// Assumes: clr has priority over adv; the count saturates at all ones.
module hsw_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    // Count advance strobes, clear on request, hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (adv && cnt != '1)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hsw_oc_filter.sv
// Module: overcurrent qualifier and fast-pulldown edge strobe.
// Assumes: ilim is synchronous to clk. oc_long goes high after ilim
// has been seen high on FILT_TICKS ticks in a row, and stays high
// until ilim drops. fast_pd marks the rising edge of ilim with no delay.
module hsw_oc_filter #(
    parameter int FILT_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim,
    input  logic tick,
    output logic oc_long,
    output logic fast_pd
);
    localparam int FW = $clog2(FILT_TICKS + 1);
    localparam logic [FW-1:0] FILT_CNT = FW'(FILT_TICKS);

    logic [FW-1:0] run_cnt;
    logic          ilim_q;

    // Count ticks of continuous current limit, saturate at the qualify length.
    always_ff @(posedge clk) begin
        if (!rst_n)                            run_cnt <= '0;
        else if (!ilim)                        run_cnt <= '0;
        else if (tick && run_cnt != FILT_CNT)  run_cnt <= run_cnt + 1'b1;
    end

    // Remember the previous current-limit level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ilim_q <= 1'b0;
        else        ilim_q <= ilim;
    end

    assign oc_long = (run_cnt == FILT_CNT);
    assign fast_pd = ilim & ~ilim_q;
endmodule

// File: rtl/hsw_chan_fsm.sv
// Module: channel sequencer state machine.
// Assumes: main_cnt counts ticks since the last state change (cleared
// through main_clr); hold_cnt counts ticks with the enable high while
// in ST_FAULT (cleared through hold_clr). Loss of either ready flag
// overrides every state.
module hsw_chan_fsm
    import hsw_pkg::*;
#(
    parameter int W          = 8,
    parameter int DEB_TICKS  = 10000,
    parameter int SU_TICKS   = 5000,
    parameter int OCB_TICKS  = 5000,
    parameter int ARM_TICKS  = 5000,
    parameter int CLR_TICKS  = 20,
    parameter int COOL_TICKS = 4000000,
    parameter bit AUTO_RETRY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_s,
    input  logic         supply_ok,
    input  logic         global_ok,
    input  logic         ilim,
    input  logic         oc_long,
    input  logic         tick,
    input  logic [W-1:0] main_cnt,
    input  logic [W-1:0] hold_cnt,
    output logic         main_clr,
    output logic         hold_clr,
    output logic         hold_adv,
    output logic         gate_on,
    output logic         fault
);
    localparam logic [W-1:0] DEB_LAST  = W'(DEB_TICKS - 1);
    localparam logic [W-1:0] SU_LAST   = W'(SU_TICKS - 1);
    localparam logic [W-1:0] OCB_LAST  = W'(OCB_TICKS - 1);
    localparam logic [W-1:0] ARM_LAST  = W'(ARM_TICKS - 1);
    localparam logic [W-1:0] CLR_LAST  = W'(CLR_TICKS - 1);
    localparam logic [W-1:0] COOL_LAST = W'(COOL_TICKS - 1);

    hsw_state_e state, nxt;
    logic on_req, lost;
    logic deb_end, su_end, ocb_end, arm_end, clr_end, cool_end;

    assign on_req = !en_s && supply_ok;
    assign lost   = !supply_ok || !global_ok;

    assign deb_end  = tick && (main_cnt == DEB_LAST);
    assign su_end   = tick && (main_cnt == SU_LAST);
    assign ocb_end  = tick && (main_cnt == OCB_LAST);
    assign arm_end  = tick && (main_cnt == ARM_LAST);
    assign clr_end  = tick && en_s && (hold_cnt == CLR_LAST);

    // Pick the cool-down completion term for the selected fault policy.
    generate
        if (AUTO_RETRY) begin : g_retry
            assign cool_end = tick && (main_cnt == COOL_LAST);
        end else begin : g_latch
            assign cool_end = 1'b0;
        end
    endgenerate

    // Next-state decision for the channel sequence.
    always_comb begin
        nxt = state;
        if (lost) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:      if (on_req) nxt = ST_DEBOUNCE;
                ST_DEBOUNCE: begin
                    if (!on_req)      nxt = ST_OFF;
                    else if (deb_end) nxt = ST_STARTUP;
                end
                ST_STARTUP: begin
                    if (en_s)         nxt = ST_OFF;
                    else if (su_end)  nxt = ilim ? ST_FAULT : ST_RUN;
                end
                ST_RUN: begin
                    if (en_s)         nxt = ST_OFF;
                    else if (oc_long) nxt = ST_OC_BLANK;
                end
                ST_OC_BLANK: begin
                    if (en_s)         nxt = ST_OFF;
                    else if (ocb_end) nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    if (en_s)         nxt = ST_OFF;
                    else if (oc_long) nxt = ST_FAULT;
                    else if (arm_end) nxt = ST_RUN;
                end
                ST_FAULT: begin
                    if (clr_end || cool_end) nxt = ST_OFF;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State register with defined reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    assign main_clr = (nxt != state);
    assign hold_clr = !en_s || (state != ST_FAULT);
    assign hold_adv = tick && en_s;

    assign gate_on = (state == ST_STARTUP) || (state == ST_RUN) ||
                     (state == ST_OC_BLANK) || (state == ST_ARMED);
    assign fault   = (state == ST_FAULT);
endmodule

// File: rtl/hsw_fault_seq.sv
// Module: top of one hot-swap channel sequencer.
// Assumes: tick_us is a one-cycle strobe; supply_ok, global_ok and
// ilim_act are already synchronous to clk; en_n is asynchronous.
// All durations are in tick_us strobes.
module hsw_fault_seq #(
    parameter int DEB_TICKS  = 10000,
    parameter int SU_TICKS   = 5000,
    parameter int FILT_TICKS = 100,
    parameter int OCB_TICKS  = 5000,
    parameter int ARM_TICKS  = 5000,
    parameter int CLR_TICKS  = 20,
    parameter int COOL_TICKS = 4000000,
    parameter bit AUTO_RETRY = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic supply_ok,
    input  logic global_ok,
    input  logic ilim_act,
    input  logic tick_us,
    output logic gate_on,
    output logic fast_pd,
    output logic fault
);
    localparam int M1 = (DEB_TICKS > SU_TICKS) ? DEB_TICKS : SU_TICKS;
    localparam int M2 = (OCB_TICKS > ARM_TICKS) ? OCB_TICKS : ARM_TICKS;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int M4 = (M3 > CLR_TICKS) ? M3 : CLR_TICKS;
    localparam int T_MAX = (AUTO_RETRY && COOL_TICKS > M4) ? COOL_TICKS : M4;
    localparam int W = $clog2(T_MAX + 1);

    logic         en_sync;
    logic         oc_long;
    logic         main_clr, hold_clr, hold_adv;
    logic [W-1:0] main_cnt, hold_cnt;

    hsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d(en_n), .q(en_sync)
    );

    hsw_oc_filter #(.FILT_TICKS(FILT_TICKS)) u_oc_filt (
        .clk(clk), .rst_n(rst_n), .ilim(ilim_act), .tick(tick_us),
        .oc_long(oc_long), .fast_pd(fast_pd)
    );

    hsw_tick_timer #(.W(W)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .clr(main_clr), .adv(tick_us), .cnt(main_cnt)
    );

    hsw_tick_timer #(.W(W)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .clr(hold_clr), .adv(hold_adv), .cnt(hold_cnt)
    );

    hsw_chan_fsm #(
        .W(W), .DEB_TICKS(DEB_TICKS), .SU_TICKS(SU_TICKS),
        .OCB_TICKS(OCB_TICKS), .ARM_TICKS(ARM_TICKS), .CLR_TICKS(CLR_TICKS),
        .COOL_TICKS(COOL_TICKS), .AUTO_RETRY(AUTO_RETRY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_s(en_sync), .supply_ok(supply_ok),
        .global_ok(global_ok), .ilim(ilim_act), .oc_long(oc_long),
        .tick(tick_us), .main_cnt(main_cnt), .hold_cnt(hold_cnt),
        .main_clr(main_clr), .hold_clr(hold_clr), .hold_adv(hold_adv),
        .gate_on(gate_on), .fault(fault)
    );
endmodule

// File: rtl/hsw_fault_seq_chk.sv
// Module: property checker for hsw_fault_seq, attached by bind.
// Assumes: en_s is the synchronised enable inside the top module.
module hsw_fault_seq_chk #(
    parameter bit AUTO_RETRY = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic supply_ok,
    input logic global_ok,
    input logic ilim_act,
    input logic gate_on,
    input logic fast_pd,
    input logic fault
);
    // R6: a latched fault never coexists with a gate request.
    p_gate_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_on && fault));

    // R6: with latch-off policy the fault holds while enabled and ready.
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!AUTO_RETRY && fault && !en_s && supply_ok && global_ok) |=> fault);

    // R9: losing either ready flag clears gate and fault on the next edge.
    p_loss_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || !global_ok) |=> (!gate_on && !fault));

    // R10: fast pulldown appears on a rising current limit.
    p_fast_pd_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ilim_act) |-> fast_pd);

    // R10: fast pulldown never appears without current limit.
    p_fast_pd_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_pd |-> ilim_act);

    // R1: the gate rises only from an enabled, ready channel.
    p_gate_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(!en_s && supply_ok && global_ok));

    // R4: a fault is only ever entered from a gate-on state.
    p_fault_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(gate_on));
endmodule

bind hsw_fault_seq hsw_fault_seq_chk #(.AUTO_RETRY(AUTO_RETRY)) u_hsw_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_sync), .supply_ok(supply_ok),
    .global_ok(global_ok), .ilim_act(ilim_act), .gate_on(gate_on),
    .fast_pd(fast_pd), .fault(fault)
);

// File: tb/test_hsw_fault_seq.sv
// Bench: sweeps overcurrent timing across blanking and arm windows on a
// scaled-down latch-off channel, plus a scaled auto-retry channel.
module test_hsw_fault_seq;
    localparam int DEB  = 8;
    localparam int SU   = 6;
    localparam int FILT = 3;
    localparam int OCB  = 6;
    localparam int ARM  = 5;
    localparam int CLR  = 4;
    localparam int COOL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1, en_ar = 1'b1;
    logic supply_ok = 1'b1, global_ok = 1'b1;
    logic ilim = 1'b0, ilim_ar = 1'b0;
    logic tick = 1'b0;
    logic gate_on, fast_pd, fault;
    logic gate_ar, fast_ar, fault_ar;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    hsw_fault_seq #(.DEB_TICKS(DEB), .SU_TICKS(SU), .FILT_TICKS(FILT),
        .OCB_TICKS(OCB), .ARM_TICKS(ARM), .CLR_TICKS(CLR),
        .COOL_TICKS(COOL), .AUTO_RETRY(1'b0)) i_hsw_fault_seq (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .supply_ok(supply_ok),
        .global_ok(global_ok), .ilim_act(ilim), .tick_us(tick),
        .gate_on(gate_on), .fast_pd(fast_pd), .fault(fault));

    hsw_fault_seq #(.DEB_TICKS(DEB), .SU_TICKS(SU), .FILT_TICKS(FILT),
        .OCB_TICKS(OCB), .ARM_TICKS(ARM), .CLR_TICKS(CLR),
        .COOL_TICKS(COOL), .AUTO_RETRY(1'b1)) i_hsw_fault_seq_ar (
        .clk(clk), .rst_n(rst_n), .en_n(en_ar), .supply_ok(supply_ok),
        .global_ok(global_ok), .ilim_act(ilim_ar), .tick_us(tick),
        .gate_on(gate_ar), .fast_pd(fast_ar), .fault(fault_ar));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic en_set(input logic v);
        en_n = v;
        cyc(4);
    endtask

    task automatic restart_run();
        en_set(1'b1);
        tk(CLR);
        en_set(1'b0);
        tk(DEB + SU);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11: reset state
        chk("R11 gate", gate_on, 1'b0);
        chk("R11 fault", fault, 1'b0);
        chk("R11 fast_pd", fast_pd, 1'b0);
        chk("R11 ar gate", gate_ar, 1'b0);

        // R1: debounce length and restart on enable bounce
        en_set(1'b0);
        tk(DEB - 1);
        chk("R1 before debounce end", gate_on, 1'b0);
        en_set(1'b1);
        en_set(1'b0);
        tk(DEB - 1);
        chk("R1 enable bounce restarts", gate_on, 1'b0);
        tk(1);
        chk("R1 debounce end", gate_on, 1'b1);
        // R2: clean start-up
        tk(SU);
        chk("R2 clean start gate", gate_on, 1'b1);
        chk("R2 clean start fault", fault, 1'b0);

        // R9: supply loss turns gate off; R1 supply bounce restarts debounce
        supply_ok = 1'b0;
        cyc(1);
        chk("R9 supply loss gate", gate_on, 1'b0);
        supply_ok = 1'b1;
        cyc(2);
        tk(DEB - 1);
        supply_ok = 1'b0;
        cyc(2);
        supply_ok = 1'b1;
        cyc(2);
        tk(DEB - 1);
        chk("R1 supply bounce restarts", gate_on, 1'b0);
        tk(1);
        chk("R1 after supply bounce", gate_on, 1'b1);
        tk(SU);

        // R2: current limit held through start-up blanking latches off
        en_set(1'b1);
        ilim = 1'b1;
        en_set(1'b0);
        tk(DEB + SU - 1);
        chk("R2 blanking not yet over", gate_on, 1'b1);
        chk("R2 no fault yet", fault, 1'b0);
        tk(1);
        chk("R2 start-up fault", fault, 1'b1);
        chk("R6 gate off on fault", gate_on, 1'b0);
        ilim = 1'b0;
        // R6: latch-off persists beyond any cool-down
        tk(COOL + 5);
        chk("R6 latch holds", fault, 1'b1);
        // R7: short release does not clear, full release does
        en_set(1'b1);
        tk(CLR - 1);
        chk("R7 short release", fault, 1'b1);
        en_set(1'b0);
        en_set(1'b1);
        tk(CLR - 1);
        chk("R7 release restarted", fault, 1'b1);
        tk(1);
        chk("R7 release clears", fault, 1'b0);
        en_set(1'b0);
        tk(DEB - 1);
        chk("R7 debounce after clear", gate_on, 1'b0);
        tk(1 + SU);
        chk("R7 back on", gate_on, 1'b1);

        // R9: global loss in run and in fault
        global_ok = 1'b0;
        cyc(1);
        chk("R9 global loss gate", gate_on, 1'b0);
        global_ok = 1'b1;
        cyc(2);
        tk(DEB + SU);
        en_set(1'b1);
        ilim = 1'b1;
        en_set(1'b0);
        tk(DEB + SU);
        chk("R9 fault before loss", fault, 1'b1);
        global_ok = 1'b0;
        cyc(1);
        chk("R9 global loss clears fault", fault, 1'b0);
        ilim = 1'b0;
        global_ok = 1'b1;
        cyc(2);
        tk(DEB + SU);
        chk("R9 recovered", gate_on, 1'b1);

        // R10: fast pulldown strobe on a rising current limit
        ilim = 1'b1;
        #1;
        chk("R10 strobe on rise", fast_pd, 1'b1);
        cyc(1);
        chk("R10 strobe one cycle", fast_pd, 1'b0);
        ilim = 1'b0;
        cyc(2);
        chk("R10 quiet when low", fast_pd, 1'b0);

        // R4 R5: sweep the gap between first and second qualification
        for (int d = 1; d <= 9; d++) begin
            int   k;
            logic exp_f;
            k = d + FILT;
            exp_f = (k >= OCB) && (k <= OCB + ARM - 1);
            ilim = 1'b1;
            tk(FILT);
            ilim = 1'b0;
            tk(d);
            ilim = 1'b1;
            tk(FILT);
            ilim = 1'b0;
            chk(exp_f ? "R4 second in arm window" : "R5 second outside window", fault, exp_f);
            chk("R4 gate versus fault", gate_on, !exp_f);
            if (exp_f) restart_run();
            else       tk(OCB + ARM + 2);
        end

        // R3: pulse length inside the arm window
        for (int l = 1; l <= FILT; l++) begin
            logic exp_f;
            exp_f = (l == FILT);
            ilim = 1'b1;
            tk(FILT);
            ilim = 1'b0;
            tk(OCB);
            ilim = 1'b1;
            tk(l);
            ilim = 1'b0;
            cyc(1);
            chk(exp_f ? "R4 qualified pulse trips" : "R3 short pulse ignored", fault, exp_f);
            if (exp_f) restart_run();
            else       tk(OCB + ARM + 2);
        end

        // R8: auto-retry channel clears after cool-down and restarts
        en_ar = 1'b0;
        ilim_ar = 1'b1;
        cyc(4);
        tk(DEB + SU);
        chk("R8 retry channel faulted", fault_ar, 1'b1);
        ilim_ar = 1'b0;
        tk(COOL - 1);
        chk("R8 before cool-down", fault_ar, 1'b1);
        tk(1);
        chk("R8 cool-down clears", fault_ar, 1'b0);
        tk(DEB - 1);
        chk("R8 debounce again", gate_ar, 1'b0);
        tk(1);
        chk("R8 restarted", gate_ar, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule